// File: doc/BRIEF.md
# Addressed SPI Target Port

This block is the target side of an SPI link. An external controller drives the serial clock, the active-low select and the controller-to-target data line. The block samples all three in the system clock domain, shifts characters in and out, and gives the host a one-deep transmit holding register, a receive buffer and status flags. It supports clock mode 0 only: the line is sampled on the rising serial clock edge, the output changes after the falling edge, and the most significant bit goes first.

When address framing is on, the first character after select falls is an address and not data. The block compares it against two programmed values in one of three ways. With a mask, bits set in the second value are ignored. With a pair, either value is accepted. With a range, any value from the first value to the second, both ends included, is accepted. On a hit, the output driver is enabled and the rest of the transaction runs as normal. On a miss, the block ignores everything until select rises. One-cycle pulses report a select-low event and an address hit; the hit pulse can serve as a wake indication.

The host can let the holding register be copied into the shifter as soon as select falls (preload), so the first character is ready before the first clock edge. Otherwise the copy happens only at a character boundary. If nothing new is waiting, the shifter sends its previous contents again.

Top module: `spi_addr_target`

## Requirements
- R1: While select is high, `spi_miso_oe` is 0 and serial clock activity neither changes `rx_valid` nor `rx_data`.
- R2: With framing off, each CHAR_W bits sampled MSB first on rising SCK form a character placed in `rx_data`, with `rx_valid` set to 1.
- R3: `spi_miso` presents the shifter MSB first. The holding register is copied into the shifter at a character boundary when `tx_empty` is 0, and `tx_empty` then returns to 1.
- R4: If the shifter was not reloaded, the next character sent repeats its previous contents.
- R5: With `cfg_preload` = 1, a full holding register is copied into the shifter when select falls. With `cfg_preload` = 0, the first character is the old shifter contents and the new data follows as the second character.
- R6: With `cfg_addr_en` = 1, the first character is an address and is never written to `rx_data`. On a hit, `spi_miso_oe` is 1 from the second character to the end, and later characters are received.
- R7: On an address miss, `spi_miso_oe` stays 0, nothing is received and the holding register is not consumed until select rises.
- R8: `cfg_amode` = 0 (mask): a hit when the address equals `cfg_addr` on every bit where `cfg_addr2` is 0.
- R9: `cfg_amode` = 1 (pair): a hit when the address equals `cfg_addr` or `cfg_addr2`.
- R10: `cfg_amode` = 2 (range): a hit when `cfg_addr` <= address <= `cfg_addr2`.
- R11: `ss_low_pulse` is high for exactly one cycle per select fall. `addr_match_pulse` is high for exactly one cycle per address hit.
- R12: A character that completes while `rx_valid` is 1 overwrites `rx_data` and sets `rx_overflow`. `rx_rd` clears both `rx_valid` and `rx_overflow`.
- R13: A select rise in the middle of a character discards the partial bits, and the next transaction starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_ss_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| spi_miso_oe | output | 1 | Output enable for the pad driver of `spi_miso` |
| cfg_addr_en | input | 1 | First character is an address |
| cfg_amode | input | 2 | Compare mode: 0 mask, 1 pair, 2 range |
| cfg_addr | input | CHAR_W | First compare value |
| cfg_addr2 | input | CHAR_W | Mask, second address or upper bound |
| cfg_preload | input | 1 | Copy holding register into shifter at select fall |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | CHAR_W | Data written to the holding register |
| tx_empty | output | 1 | Holding register free |
| rx_rd | input | 1 | Read acknowledge; clears receive flags |
| rx_data | output | CHAR_W | Last received character |
| rx_valid | output | 1 | Unread character present |
| rx_overflow | output | 1 | A character was overwritten before it was read |
| ss_low_pulse | output | 1 | One-cycle select-low event |
| addr_match_pulse | output | 1 | One-cycle address hit (wake) |

## Verification
The bench builds the block with CHAR_W = 8 and SYNC_STAGES = 2. With an 8-bit character, the range bounds (both ends and one step outside each) fit in a short table, as do the mask don't-care bits and both members of an address pair. With two sync stages, the output settles three system cycles after each serial edge. A serial half-period of six system cycles therefore tests the data-out setup with little margin, while preload and non-preload ordering can both be checked bit by bit on the line.

// File: rtl/spi_addr_pkg.sv
package spi_addr_pkg;

    typedef enum logic [1:0] {
        AM_MASK  = 2'd0,
        AM_PAIR  = 2'd1,
        AM_RANGE = 2'd2
    } amode_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] prev_o
);

    logic [N-1:0] stage_q [STAGES];
    logic [N-1:0] prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/spi_addr_cmp.sv
module spi_addr_cmp
    import spi_addr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] ref_a_i,
    input  logic [W-1:0] ref_b_i,
    input  logic [W-1:0] cand_i,
    output logic         hit_o
);

    logic [W-1:0] bit_ok;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            assign bit_ok[b] = ref_b_i[b] | ~(cand_i[b] ^ ref_a_i[b]);
        end
    endgenerate

    always_comb begin
        case (mode_i)
            AM_MASK:  hit_o = &bit_ok;
            AM_PAIR:  hit_o = (cand_i == ref_a_i) || (cand_i == ref_b_i);
            AM_RANGE: hit_o = (cand_i >= ref_a_i) && (cand_i <= ref_b_i);
            default:  hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_addr_target.sv
module spi_addr_target #(
    parameter int CHAR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_ss_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              cfg_addr_en,
    input  logic [1:0]        cfg_amode,
    input  logic [CHAR_W-1:0] cfg_addr,
    input  logic [CHAR_W-1:0] cfg_addr2,
    input  logic              cfg_preload,
    input  logic              tx_wr,
    input  logic [CHAR_W-1:0] tx_data,
    output logic              tx_empty,
    input  logic              rx_rd,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_overflow,
    output logic              ss_low_pulse,
    output logic              addr_match_pulse
);

    localparam int CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        logic [CHAR_W-1:0] tx_shift;
        logic [CHAR_W-1:0] tx_hold;
        logic              tx_empty;
        logic              skip_fall;
        logic [CHAR_W-1:0] rx_shift;
        logic [CNT_W-1:0]  bit_cnt;
        logic              active;
        logic              addr_phase;
        logic              matched;
        logic              ignore;
        logic [CHAR_W-1:0] rx_data;
        logic              rx_valid;
        logic              rx_ovf;
        logic              ss_pulse;
        logic              match_pulse;
    } st_t;

    st_t st_d, st_q;

    // synchronised pins: bit 0 SCK, bit 1 select, bit 2 data in
    logic [2:0] pin_s, pin_p;

    spi_pin_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({spi_mosi, spi_ss_n, spi_sck}),
        .sync_o (pin_s),
        .prev_o (pin_p)
    );

    logic sck_rise, sck_fall, ss_fall, ss_rise, mosi_s;
    assign sck_rise = pin_s[0] & ~pin_p[0];
    assign sck_fall = ~pin_s[0] & pin_p[0];
    assign ss_fall  = ~pin_s[1] & pin_p[1];
    assign ss_rise  = pin_s[1] & ~pin_p[1];
    assign mosi_s   = pin_s[2];

    logic [CHAR_W-1:0] rx_word;
    logic              addr_hit;
    assign rx_word = {st_q.rx_shift[CHAR_W-2:0], mosi_s};

    spi_addr_cmp #(.W(CHAR_W)) u_cmp (
        .mode_i  (cfg_amode),
        .ref_a_i (cfg_addr),
        .ref_b_i (cfg_addr2),
        .cand_i  (rx_word),
        .hit_o   (addr_hit)
    );

    always_comb begin
        logic load_now;
        st_d             = st_q;
        st_d.ss_pulse    = 1'b0;
        st_d.match_pulse = 1'b0;
        load_now         = 1'b0;

        if (rx_rd) begin
            st_d.rx_valid = 1'b0;
            st_d.rx_ovf   = 1'b0;
        end

        if (ss_fall) begin
            st_d.active     = 1'b1;
            st_d.bit_cnt    = '0;
            st_d.addr_phase = cfg_addr_en;
            st_d.matched    = 1'b0;
            st_d.ignore     = 1'b0;
            st_d.skip_fall  = 1'b0;
            st_d.ss_pulse   = 1'b1;
            if (cfg_preload && !st_q.tx_empty) begin
                st_d.tx_shift = st_q.tx_hold;
                st_d.tx_empty = 1'b1;
            end
        end else if (ss_rise) begin
            st_d.active     = 1'b0;
            st_d.bit_cnt    = '0;
            st_d.addr_phase = 1'b0;
            st_d.matched    = 1'b0;
            st_d.ignore     = 1'b0;
            st_d.skip_fall  = 1'b0;
        end else if (st_q.active) begin
            if (sck_rise) begin
                st_d.rx_shift = rx_word;
                if (st_q.bit_cnt == LAST_BIT) begin
                    st_d.bit_cnt = '0;
                    if (st_q.addr_phase) begin
                        st_d.addr_phase = 1'b0;
                        if (addr_hit) begin
                            st_d.matched     = 1'b1;
                            st_d.match_pulse = 1'b1;
                            load_now         = 1'b1;
                        end else begin
                            st_d.ignore = 1'b1;
                        end
                    end else if (!st_q.ignore) begin
                        st_d.rx_data  = rx_word;
                        st_d.rx_valid = 1'b1;
                        if (st_q.rx_valid && !rx_rd) st_d.rx_ovf = 1'b1;
                        load_now = 1'b1;
                    end
                end else begin
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                end
            end
            if (sck_fall) begin
                if (st_q.skip_fall) st_d.skip_fall = 1'b0;
                else st_d.tx_shift = {st_q.tx_shift[CHAR_W-2:0], st_q.tx_shift[CHAR_W-1]};
            end
        end

        if (load_now && !st_q.tx_empty) begin
            st_d.tx_shift  = st_q.tx_hold;
            st_d.tx_empty  = 1'b1;
            st_d.skip_fall = 1'b1;
        end

        if (tx_wr) begin
            st_d.tx_hold  = tx_data;
            st_d.tx_empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.tx_empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_miso         = st_q.tx_shift[CHAR_W-1];
    assign spi_miso_oe      = st_q.active & ~st_q.addr_phase & ~st_q.ignore;
    assign tx_empty         = st_q.tx_empty;
    assign rx_data          = st_q.rx_data;
    assign rx_valid         = st_q.rx_valid;
    assign rx_overflow      = st_q.rx_ovf;
    assign ss_low_pulse     = st_q.ss_pulse;
    assign addr_match_pulse = st_q.match_pulse;

    // R1
    oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> !pin_p[1]);

    // R7
    miss_keeps_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ignore |-> (!spi_miso_oe && !addr_match_pulse));

    // R11
    ss_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_low_pulse |=> !ss_low_pulse);

    // R6
    match_needs_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match_pulse |-> (cfg_addr_en && st_q.active));

    // R12
    overflow_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overflow) |-> $past(rx_valid));

endmodule

// File: tb/spi_addr_target_test.sv
module spi_addr_target_test;

    localparam int W    = 8;
    localparam int HALF = 6;
    localparam int NV   = 10;

    // {mode[2], addr[8], addr2[8], address char[8], expected hit[1]}
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 8'h40, 8'h0F, 8'h4A, 1'b1},
        {2'd0, 8'h40, 8'h0F, 8'h50, 1'b0},
        {2'd1, 8'h12, 8'h34, 8'h12, 1'b1},
        {2'd1, 8'h12, 8'h34, 8'h34, 1'b1},
        {2'd1, 8'h12, 8'h34, 8'h13, 1'b0},
        {2'd2, 8'h20, 8'h30, 8'h20, 1'b1},
        {2'd2, 8'h20, 8'h30, 8'h30, 1'b1},
        {2'd2, 8'h20, 8'h30, 8'h31, 1'b0},
        {2'd2, 8'h20, 8'h30, 8'h1F, 1'b0},
        {2'd0, 8'h77, 8'h00, 8'h77, 1'b1}
    };

    logic clk = 0, rst_n = 0;
    logic sck = 0, ss_n = 1, mosi = 0;
    logic miso, oe;
    logic addr_en = 0, preload = 0;
    logic [1:0] amode = 0;
    logic [W-1:0] addr = 0, addr2 = 0, txd = 0;
    logic tx_wr = 0, rx_rd = 0;
    logic tx_empty, rx_valid, rx_ovf, ss_p, m_p;
    logic [W-1:0] rxd;

    int n_chk = 0, n_fail = 0, ss_cnt = 0, m_cnt = 0;

    always #5 clk = ~clk;

    spi_addr_target #(.CHAR_W(W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_ss_n(ss_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(oe), .cfg_addr_en(addr_en), .cfg_amode(amode),
        .cfg_addr(addr), .cfg_addr2(addr2), .cfg_preload(preload), .tx_wr(tx_wr),
        .tx_data(txd), .tx_empty(tx_empty), .rx_rd(rx_rd), .rx_data(rxd),
        .rx_valid(rx_valid), .rx_overflow(rx_ovf), .ss_low_pulse(ss_p),
        .addr_match_pulse(m_p)
    );

    always @(negedge clk) begin
        if (ss_p) ss_cnt++;
        if (m_p)  m_cnt++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [W-1:0] v);
        txd = v; tx_wr = 1; tick(1); tx_wr = 0;
    endtask

    task automatic host_read();
        rx_rd = 1; tick(1); rx_rd = 0;
    endtask

    task automatic sel(input logic low);
        if (low) begin ss_n = 0; tick(HALF); end
        else begin tick(HALF); ss_n = 1; tick(HALF); end
    endtask

    task automatic xfer(input logic [W-1:0] mo, output logic [W-1:0] mi,
                        output logic oe_all, output logic oe_any);
        oe_all = 1; oe_any = 0;
        for (int i = W - 1; i >= 0; i--) begin
            mosi = mo[i];
            tick(HALF);
            mi[i] = miso;
            oe_all &= oe;
            oe_any |= oe;
            sck = 1;
            tick(HALF);
            sck = 0;
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] mi;
        logic all_o, any_o;
        int ss0, m0;

        tick(3);
        chk("R1 reset oe", {31'd0, oe}, 0);
        chk("R3 reset tx_empty", {31'd0, tx_empty}, 1);
        chk("R2 reset rx_valid", {31'd0, rx_valid}, 0);
        chk("R12 reset overflow", {31'd0, rx_ovf}, 0);
        rst_n = 1;
        tick(3);

        // R1: clock toggling with select high
        xfer(8'hFF, mi, all_o, any_o);
        tick(HALF);
        chk("R1 no receive while deselected", {31'd0, rx_valid}, 0);
        chk("R1 oe off while deselected", {31'd0, any_o}, 0);

        // R2 R3 R5: preload on, framing off
        preload = 1;
        host_write(8'hA5);
        ss0 = ss_cnt;
        sel(1);
        chk("R5 preload consumed at select fall", {31'd0, tx_empty}, 1);
        xfer(8'h3C, mi, all_o, any_o);
        sel(0);
        chk("R3 miso with preload", {24'd0, mi}, 32'hA5);
        chk("R3 oe during data", {31'd0, all_o}, 1);
        chk("R2 rx data", {24'd0, rxd}, 32'h3C);
        chk("R2 rx valid", {31'd0, rx_valid}, 1);
        chk("R11 one ss pulse", ss_cnt - ss0, 1);
        host_read();
        chk("R12 read clears valid", {31'd0, rx_valid}, 0);

        // R4: nothing new, old contents repeat
        sel(1);
        xfer(8'h00, mi, all_o, any_o);
        sel(0);
        chk("R4 repeat old contents", {24'd0, mi}, 32'hA5);
        host_read();

        // R5 R12: no preload, two characters, no read between
        preload = 0;
        host_write(8'h5A);
        sel(1);
        chk("R5 not consumed at fall", {31'd0, tx_empty}, 0);
        xfer(8'h11, mi, all_o, any_o);
        chk("R5 first char is old contents", {24'd0, mi}, 32'hA5);
        chk("R3 loaded at boundary", {31'd0, tx_empty}, 1);
        xfer(8'h22, mi, all_o, any_o);
        chk("R5 second char is new data", {24'd0, mi}, 32'h5A);
        sel(0);
        chk("R12 overwrite data", {24'd0, rxd}, 32'h22);
        chk("R12 overflow set", {31'd0, rx_ovf}, 1);
        host_read();
        chk("R12 read clears overflow", {31'd0, rx_ovf}, 0);

        // R13: partial character then a full one
        ss_n = 0; tick(HALF);
        for (int i = 0; i < 3; i++) begin
            mosi = 1; tick(HALF); sck = 1; tick(HALF); sck = 0;
        end
        sel(0);
        chk("R13 partial discarded", {31'd0, rx_valid}, 0);
        sel(1);
        xfer(8'h81, mi, all_o, any_o);
        sel(0);
        chk("R13 fresh start", {24'd0, rxd}, 32'h81);
        host_read();

        // R6..R10: address table
        addr_en = 1;
        for (int v = 0; v < NV; v++) begin
            logic hit_e;
            logic [W-1:0] ach, tv;
            {amode, addr, addr2, ach, hit_e} = VEC[v];
            tv = 8'hC3 ^ W'(v);
            host_write(tv);
            m0 = m_cnt;
            sel(1);
            xfer(ach, mi, all_o, any_o);
            chk($sformatf("R6 oe off in address v%0d", v), {31'd0, any_o}, 0);
            xfer(8'h60 + W'(v), mi, all_o, any_o);
            sel(0);
            if (hit_e) begin
                chk($sformatf("R8 R9 R10 hit oe v%0d", v), {31'd0, all_o}, 1);
                chk($sformatf("R6 data out v%0d", v), {24'd0, mi}, {24'd0, tv});
                chk($sformatf("R6 data in v%0d", v), {24'd0, rxd}, 32'h60 + v);
                chk($sformatf("R6 address not stored v%0d", v), {31'd0, rx_ovf}, 0);
                chk($sformatf("R11 match pulse v%0d", v), m_cnt - m0, 1);
            end else begin
                chk($sformatf("R7 miss oe v%0d", v), {31'd0, any_o}, 0);
                chk($sformatf("R7 miss no rx v%0d", v), {31'd0, rx_valid}, 0);
                chk($sformatf("R7 miss keeps hold v%0d", v), {31'd0, tx_empty}, 0);
                chk($sformatf("R11 no match pulse v%0d", v), m_cnt - m0, 0);
            end
            if (rx_valid) host_read();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule